// File: doc/BRIEF.md
# System Control Register Bank

This block holds the global control and status words of a chip: identification, captured strap pins, interrupt routing controls, reset and boot status, lock bits, a module-disable mask and scratchpad words. Software reaches it through a simple word-wide bus with a select, a write strobe, a byte address inside a 4 KiB window, write data and registered read data. Each word follows its own access rule: plain read/write, read-only, write-one-to-clear or write-one-to-set. Index positions that hold no register read as zero and take no writes.

On a synchronous cold reset every word loads its start value. Most are constants; the strap word and the module-disable word copy input vectors, and the third interrupt control word carries a code derived from the memory size input given in MiB. A memory size outside the supported range raises a held configuration error. Accesses past the implemented words, misaligned accesses and writes to read-only words are answered with a one-cycle error pulse and change nothing.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is bus_addr[11:2]; a read returns the word on bus_rdata in the cycle after the access, and bus_rdata is zero in any cycle that does not follow a valid read.
- R2: An access with a word index of 16 or more, or with bus_addr[1:0] nonzero, is out of range: a read returns zero and a write changes no word.
- R3: Words at indices 0 (identification), 1 (straps) and 2 (interrupt status) are read-only; writes to them leave them unchanged.
- R4: Words at indices 8 (lock) and 9 (module disable) are write-one-to-set: the new value is the old value OR the write data, so no bit can be cleared by a write.
- R5: Words at indices 6 (reset status) and 7 (boot status) are write-one-to-clear: the new value is the old value AND NOT the write data.
- R6: Words at indices 3, 4, 5, 10 and 12 are plain read/write; indices 11, 13, 14 and 15 are gaps that read zero and ignore writes without an error.
- R7: After reset, index 0 reads 0x04A92750, index 3 reads 0x0000035E, index 4 reads 0x00080000 (bit 19 set: memory already initialised), index 6 reads 0x80000000, index 10 reads 0x00000008, and indices 2, 7, 8, 12 read zero.
- R8: After reset, index 1 holds strap_pins and index 9 holds module_mask as sampled during reset.
- R9: After reset, index 5 reads 0x00001002 OR (code << 8), where code is 4 for dram_mib >= 2048, 3 for >= 1024, 2 for >= 512, 1 for >= 256 and 0 otherwise.
- R10: cfg_error is loaded during reset, set when dram_mib is below 128 or above 2048, and held until the next reset.
- R11: bus_err is high for exactly the one cycle after an out-of-range access or a write to a read-only word, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous cold reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse |
| strap_pins | input | 32 | Reset value of the strap word |
| module_mask | input | 32 | Reset value of the module-disable word |
| dram_mib | input | 16 | Memory size in MiB |
| cfg_error | output | 1 | Unsupported memory size, held |

## Verification
The bench walks the memory-size thresholds on both sides (127/128, 255/256, 2047/2048/2049); an encoder with an off-by-one compare would put the wrong code in index 5 or miss the error flag at the edges. It writes all-ones and then zeros to the sticky and clearing words, where a design that treated them as plain storage would lose or keep bits it must not. Misaligned addresses, indices just past the last word and far beyond it, and gap indices are mixed into a long random run against a shadow model, so a decoder that aliased high indices onto real words or flagged gaps as errors would show a data or error mismatch.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NUM_REGS = 16;
  localparam int RIDX_W   = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    POL_GAP = 3'd0,
    POL_RW  = 3'd1,
    POL_RO  = 3'd2,
    POL_W1C = 3'd3,
    POL_W1S = 3'd4
  } policy_e;

  // word map
  localparam int IX_IDENT   = 0;
  localparam int IX_STRAP   = 1;
  localparam int IX_IRQSTAT = 2;
  localparam int IX_ICTL1   = 3;
  localparam int IX_ICTL2   = 4;
  localparam int IX_ICTL3   = 5;
  localparam int IX_RSTSTAT = 6;
  localparam int IX_BOOTST  = 7;
  localparam int IX_LOCK    = 8;
  localparam int IX_MODDIS  = 9;
  localparam int IX_SCR0    = 10;
  localparam int IX_SCR1    = 12;

  // memory size thresholds in MiB
  localparam int unsigned MIB_MIN  = 128;
  localparam int unsigned MIB_MAX  = 2048;

  function automatic policy_e reg_policy(input int idx);
    case (idx)
      IX_IDENT, IX_STRAP, IX_IRQSTAT:               return POL_RO;
      IX_RSTSTAT, IX_BOOTST:                        return POL_W1C;
      IX_LOCK, IX_MODDIS:                           return POL_W1S;
      IX_ICTL1, IX_ICTL2, IX_ICTL3, IX_SCR0, IX_SCR1: return POL_RW;
      default:                                      return POL_GAP;
    endcase
  endfunction

  function automatic logic [31:0] reset_const(input int idx);
    case (idx)
      IX_IDENT:   return 32'h04A9_2750;
      IX_ICTL1:   return 32'h0000_035E;
      IX_ICTL2:   return 32'h0008_0000;
      IX_ICTL3:   return 32'h0000_1002;
      IX_RSTSTAT: return 32'h8000_0000;
      IX_SCR0:    return 32'h0000_0008;
      default:    return 32'h0000_0000;
    endcase
  endfunction

  // size code placed at bit 8 of the third interrupt control word
  function automatic logic [2:0] dram_code(input int unsigned mib);
    if (mib >= 32'd2048)      return 3'd4;
    else if (mib >= 32'd1024) return 3'd3;
    else if (mib >= 32'd512)  return 3'd2;
    else if (mib >= 32'd256)  return 3'd1;
    else                      return 3'd0;
  endfunction

  function automatic logic dram_bad(input int unsigned mib);
    return (mib < MIB_MIN) || (mib > MIB_MAX);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [RIDX_W-1:0] idx,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              oor_hit,
  output logic              ro_viol
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             in_range;
  policy_e          pol;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_range = aligned && (int'(word_idx) < NUM_REGS);
  assign idx      = word_idx[RIDX_W-1:0];

  always_comb pol = reg_policy(int'(idx));

  assign rd_hit  = bus_sel && !bus_we && in_range;
  assign wr_hit  = bus_sel &&  bus_we && in_range;
  assign oor_hit = bus_sel && !in_range;
  assign ro_viol = wr_hit && (pol == POL_RO);
endmodule

// File: rtl/sysctl_size_enc.sv
module sysctl_size_enc
  import sysctl_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic [SIZE_W-1:0] dram_mib,
  output logic [2:0]        code,
  output logic              bad
);
  int unsigned mib_u;
  assign mib_u = 32'(dram_mib);
  assign code  = dram_code(mib_u);
  assign bad   = dram_bad(mib_u);
endmodule

// File: rtl/sysctl_reg_cell.sv
module sysctl_reg_cell
  import sysctl_pkg::*;
#(
  parameter int      W      = 32,
  parameter policy_e POLICY = POL_RW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init_val,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= init_val;
    end else if (wr_en) begin
      case (POLICY)
        POL_RW:  q <= wdata;
        POL_W1C: q <= q & ~wdata;
        POL_W1S: q <= q | wdata;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [DATA_W-1:0] strap_pins,
  input  logic [DATA_W-1:0] module_mask,
  input  logic [SIZE_W-1:0] dram_mib,
  output logic              cfg_error
);
  localparam int CODE_LSB = 8;

  // decoder events, named for the checker
  logic [RIDX_W-1:0] idx;
  logic              rd_hit;
  logic              wr_hit;
  logic              oor_hit;
  logic              ro_viol;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .idx     (idx),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .oor_hit (oor_hit),
    .ro_viol (ro_viol)
  );

  logic [2:0] size_code;
  logic       size_bad;

  sysctl_size_enc #(.SIZE_W(SIZE_W)) u_size (
    .dram_mib(dram_mib),
    .code    (size_code),
    .bad     (size_bad)
  );

  logic [DATA_W-1:0] ictl3_init;
  assign ictl3_init = DATA_W'(reset_const(IX_ICTL3))
                    | (DATA_W'(size_code) << CODE_LSB);

  logic [DATA_W-1:0] reg_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam policy_e P = reg_policy(i);
    if (P == POL_GAP) begin : g_gap
      assign reg_q[i] = '0;
    end else begin : g_cell
      logic [DATA_W-1:0] init_v;
      if (i == IX_STRAP) begin : g_strap
        assign init_v = strap_pins;
      end else if (i == IX_MODDIS) begin : g_mask
        assign init_v = module_mask;
      end else if (i == IX_ICTL3) begin : g_size
        assign init_v = ictl3_init;
      end else begin : g_const
        assign init_v = DATA_W'(reset_const(i));
      end
      sysctl_reg_cell #(.W(DATA_W), .POLICY(P)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_val(init_v),
        .wr_en   (wr_hit && (idx == RIDX_W'(i))),
        .wdata   (bus_wdata),
        .q       (reg_q[i])
      );
    end
  end

  // registered read path and error pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      cfg_error <= size_bad;
    end else begin
      bus_rdata <= rd_hit ? reg_q[idx] : '0;
      bus_err   <= oor_hit || ro_viol;
    end
  end

  // named words for the checker
  logic [DATA_W-1:0] strap_word;
  logic [DATA_W-1:0] lock_word;
  logic [DATA_W-1:0] moddis_word;
  logic [DATA_W-1:0] rststat_word;
  logic [DATA_W-1:0] bootst_word;
  assign strap_word   = reg_q[IX_STRAP];
  assign lock_word    = reg_q[IX_LOCK];
  assign moddis_word  = reg_q[IX_MODDIS];
  assign rststat_word = reg_q[IX_RSTSTAT];
  assign bootst_word  = reg_q[IX_BOOTST];
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_hit,
  input logic              oor_hit,
  input logic              ro_viol,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic [DATA_W-1:0] strap_word,
  input logic [DATA_W-1:0] lock_word,
  input logic [DATA_W-1:0] moddis_word,
  input logic [DATA_W-1:0] rststat_word,
  input logic [DATA_W-1:0] bootst_word,
  input logic              cfg_error
);
  a_r1_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (bus_rdata == '0));

  a_r2_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oor_hit |=> (bus_rdata == '0));

  a_r3_strap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_word));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((lock_word & $past(lock_word)) == $past(lock_word)));

  a_r4_moddis_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((moddis_word & $past(moddis_word)) == $past(moddis_word)));

  a_r5_rststat_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((rststat_word | $past(rststat_word)) == $past(rststat_word)));

  a_r5_bootst_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((bootst_word | $past(bootst_word)) == $past(bootst_word)));

  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg_error));

  a_r11_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_hit || ro_viol) |=> bus_err);

  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(oor_hit || ro_viol) |=> !bus_err);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_hit      (rd_hit),
  .oor_hit     (oor_hit),
  .ro_viol     (ro_viol),
  .bus_rdata   (bus_rdata),
  .bus_err     (bus_err),
  .strap_word  (strap_word),
  .lock_word   (lock_word),
  .moddis_word (moddis_word),
  .rststat_word(rststat_word),
  .bootst_word (bootst_word),
  .cfg_error   (cfg_error)
);

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [31:0] strap_pins = '0;
  logic [31:0] module_mask = '0;
  logic [15:0] dram_mib = 16'd1024;
  logic        cfg_error;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk;

  sysctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .strap_pins(strap_pins), .module_mask(module_mask),
    .dram_mib(dram_mib), .cfg_error(cfg_error)
  );

  // 0 gap, 1 rw, 2 ro, 3 w1c, 4 w1s
  function automatic int kind_of(input int i);
    if (i <= 2) return 2;
    if (i == 6 || i == 7) return 3;
    if (i == 8 || i == 9) return 4;
    if (i == 11 || i >= 13) return 0;
    return 1;
  endfunction

  function automatic logic [2:0] size_code(input int mib);
    int limits [4] = '{256, 512, 1024, 2048};
    logic [2:0] c = 0;
    foreach (limits[k]) if (mib >= limits[k]) c = 3'(k + 1);
    return c;
  endfunction

  function automatic logic size_bad(input int mib);
    return !(mib >= 128 && mib <= 2048);
  endfunction

  function automatic logic [31:0] start_val(input int i);
    case (i)
      0:  return 32'h04A92750;
      1:  return strap_pins;
      3:  return 32'h0000035E;
      4:  return 32'h1 << 19;
      5:  return 32'h00001002 + (32'(size_code(int'(dram_mib))) << 8);
      6:  return 32'h80000000;
      9:  return module_mask;
      10: return 32'h00000008;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] mib);
    @(negedge clk);
    rst_n = 1'b0;
    bus_sel = 1'b0;
    dram_mib = mib;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = start_val(i);
  endtask

  task automatic access(input string req, input logic we,
                        input logic [11:0] addr, input logic [31:0] wd);
    int idx = int'(addr[11:2]);
    logic oor = (addr[1:0] != 2'b00) || (idx >= 16);
    int k = oor ? 0 : kind_of(idx);
    logic [31:0] exp_rd = (!we && !oor) ? model[idx] : 32'h0;
    logic exp_err = oor || (we && k == 2);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk(req, "rdata", bus_rdata, exp_rd);
    chk(req, "err", {31'b0, bus_err}, {31'b0, exp_err});
    if (we && !oor) begin
      case (k)
        1: model[idx] = wd;
        3: model[idx] = model[idx] & ~wd;
        4: model[idx] = model[idx] | wd;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input string req, input int i);
    access(req, 1'b0, 12'(i << 2), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    strap_pins  = $urandom;
    module_mask = $urandom;
    do_reset(16'd1024);

    // R1 idle output and R11 quiet error right after reset
    @(negedge clk);
    chk("R1", "idle rdata", bus_rdata, 32'h0);
    chk("R11", "idle err", {31'b0, bus_err}, 32'h0);
    chk("R10", "cfg_error 1024", {31'b0, cfg_error}, 32'h0);

    // R7 R8 R9 reset contents
    for (int i = 0; i < 16; i++) rd((i == 1 || i == 9) ? "R8" : (i == 5 ? "R9" : "R7"), i);

    // R3 read-only words
    access("R3", 1'b1, 12'h000, 32'hFFFFFFFF);
    access("R3", 1'b1, 12'h004, 32'h0);
    access("R3", 1'b1, 12'h008, 32'hA5A5A5A5);
    rd("R3", 0); rd("R3", 1); rd("R3", 2);

    // R5 clearing words
    access("R5", 1'b1, 12'h018, 32'h80000000);
    rd("R5", 6);
    access("R5", 1'b1, 12'h01C, 32'hFFFFFFFF);
    rd("R5", 7);

    // R4 sticky words
    access("R4", 1'b1, 12'h020, 32'h1);
    access("R4", 1'b1, 12'h020, 32'h2);
    access("R4", 1'b1, 12'h020, 32'h0);
    rd("R4", 8);
    chk("R4", "lock value", model[8], 32'h3);
    access("R4", 1'b1, 12'h024, 32'hF0000000);
    rd("R4", 9);

    // R6 read/write and gaps
    access("R6", 1'b1, 12'h028, 32'hDEADBEEF);
    rd("R6", 10);
    access("R6", 1'b1, 12'h030, 32'h12345678);
    rd("R6", 12);
    access("R6", 1'b1, 12'h02C, 32'hFFFFFFFF);
    rd("R6", 11);
    access("R6", 1'b1, 12'h03C, 32'hFFFFFFFF);
    rd("R6", 15);

    // R2 out of range and misaligned
    access("R2", 1'b1, 12'h040, 32'hFFFFFFFF);
    access("R2", 1'b0, 12'h040, 32'h0);
    access("R2", 1'b1, 12'h029, 32'h0);
    rd("R2", 10);
    access("R2", 1'b0, 12'hFFC, 32'h0);
    access("R2", 1'b1, 12'hFFC, 32'h0);
    for (int i = 0; i < 16; i++) rd("R2", i);

    // R11 random mix against the model
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 15));
      logic [11:0] a;
      if (r == 0) a = 12'($urandom_range(16, 1023) << 2);
      else if (r == 1) a = 12'(($urandom_range(0, 15) << 2) | $urandom_range(1, 3));
      else a = 12'($urandom_range(0, 15) << 2);
      access("R11", 1'($urandom_range(0, 1)), a, $urandom);
    end
    for (int i = 0; i < 16; i++) rd("R6", i);

    // R9 R10 memory size thresholds
    begin
      int sizes [11] = '{64, 127, 128, 255, 256, 511, 512, 1023, 2047, 2048, 2049};
      foreach (sizes[s]) begin
        do_reset(16'(sizes[s]));
        @(negedge clk);
        chk("R10", "cfg_error", {31'b0, cfg_error}, {31'b0, size_bad(sizes[s])});
        rd("R9", 5);
        access("R10", 1'b1, 12'h014, 32'h0);
        chk("R10", "cfg_error held", {31'b0, cfg_error}, {31'b0, size_bad(sizes[s])});
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule